// File: doc/BRIEF.md
# Sequence-Triggered Input Bit Corruptor

This block sits on an 8-bit data input bus in front of a downstream core. It watches two bit lanes of the bus (lane 0 and lane 2) and keeps a separate 15-deep history of each. A history takes a new sample only on a cycle where the new-data strobe is high. When both histories together hold a 30-bit trigger pattern fixed at build time, the block inverts a third lane (lane 1) of the bus on its way to the core. Every other lane passes through unchanged.

The block is fully synchronous. The strobe acts as a shift enable and is never used as a clock. The match is worked out from the stored history combined with the transfer now at the input. The transfer that completes the pattern is therefore the first one corrupted. The corruption stays in force for as long as the stored history still holds the pattern. The bus output and a match flag are registered, which gives one cycle of latency.

Top module: `lane_trigger_corruptor`

## Requirements
- R1: A synchronous active-high reset clears both histories, the bus output and the match flag to zero. Each trigger pattern parameter must be non-zero, so a cleared history cannot match.
- R2: A history shifts only when `valid_i` is 1. The newest sample enters at bit 0, so bit 14 holds the oldest of the last 15 strobed samples. Lane values on cycles without the strobe are not stored.
- R3: The match is 1 only when the lane-0 history equals `PAT_A` and the lane-2 history equals `PAT_B`, both counted after the current transfer has been taken in. Pattern bit 14 is compared with the oldest sample and bit 0 with the newest.
- R4: On a cycle where the match is 1, output bit 1 is input bit 1 inverted.
- R5: Output bits 0 and 2 to 7 equal the input bits of the previous cycle. Bit 1 also equals its input bit whenever the match is 0.
- R6: Once matched, the match flag stays at 1 through cycles without the strobe, and lane 1 stays inverted on those cycles.
- R7: A strobed transfer that moves either history off its pattern clears the match from that transfer onward.
- R8: If only one of the two lanes holds its pattern, there is no match and no corruption.
- R9: `match_o` shows the registered comparator result. It is aligned with the `data_o` value that it corrupted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | New-data strobe, used as the history shift enable |
| data_i | input | 8 | Incoming data bus |
| data_o | output | 8 | Registered bus to the core, lane 1 possibly inverted |
| match_o | output | 1 | Registered trigger comparator result |

## Verification
Two things can happen in the same cycle: the history shift that a strobe causes, and the corruption of that same transfer's lane 1. The bench provokes this by feeding the 15th pattern transfer with bit 1 set to known values. It then judges the output one cycle later: the output must already show bit 1 flipped, and the flag must rise together with it. A second collision pits a strobed transfer that breaks the pattern against a held match. That transfer must pass unflipped, with the flag falling in the same output cycle.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int unsigned BUS_W_DEF  = 8;
  localparam int unsigned HIST_W_DEF = 15;
  localparam int unsigned NLANE      = 2;
endpackage

// File: rtl/lane_history.sv
module lane_history #(
  parameter int unsigned HIST_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_next
);
  logic [HIST_W-1:0] hist_q;

  // View of the history including the transfer now on the bus
  always_comb begin
    if (shift_en) hist_next = {hist_q[HIST_W-2:0], bit_in};
    else          hist_next = hist_q;
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= hist_next;
  end
endmodule

// File: rtl/pattern_match.sv
module pattern_match #(
  parameter int unsigned        W   = 15,
  parameter logic [W-1:0]       PAT = '1
) (
  input  logic [W-1:0] vec,
  output logic         hit
);
  logic [W-1:0] eq;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign eq[i] = ~(vec[i] ^ PAT[i]);
    end
  endgenerate

  assign hit = &eq;
endmodule

// File: rtl/lane_trigger_corruptor.sv
module lane_trigger_corruptor #(
  parameter int unsigned BUS_W     = ltc_pkg::BUS_W_DEF,
  parameter int unsigned HIST_W    = ltc_pkg::HIST_W_DEF,
  parameter int unsigned TAP_A     = 0,
  parameter int unsigned TAP_B     = 2,
  parameter int unsigned FLIP_LANE = 1,
  parameter logic [HIST_W-1:0] PAT_A = 15'h5A3C,
  parameter logic [HIST_W-1:0] PAT_B = 15'h2B17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [BUS_W-1:0] data_o,
  output logic             match_o
);
  localparam int unsigned NL = ltc_pkg::NLANE;
  localparam logic [BUS_W-1:0] FLIP_MASK = BUS_W'(1) << FLIP_LANE;

  logic [NL-1:0] lane_hit;
  logic          hit;

  genvar g;
  generate
    for (g = 0; g < NL; g++) begin : g_lane
      localparam int unsigned TAP = (g == 0) ? TAP_A : TAP_B;
      localparam logic [HIST_W-1:0] PAT = (g == 0) ? PAT_A : PAT_B;
      logic [HIST_W-1:0] nxt;

      lane_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (valid_i),
        .bit_in   (data_i[TAP]),
        .hist_next(nxt)
      );

      pattern_match #(.W(HIST_W), .PAT(PAT)) u_cmp (
        .vec(nxt),
        .hit(lane_hit[g])
      );
    end
  endgenerate

  assign hit = &lane_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o  <= '0;
      match_o <= 1'b0;
    end else begin
      data_o  <= data_i ^ (hit ? FLIP_MASK : '0);
      match_o <= hit;
    end
  end
endmodule

// File: rtl/lane_trigger_corruptor_chk.sv
module lane_trigger_corruptor_chk #(
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned HIST_W    = 15,
  parameter int unsigned TAP_A     = 0,
  parameter int unsigned TAP_B     = 2,
  parameter int unsigned FLIP_LANE = 1,
  parameter logic [HIST_W-1:0] PAT_A = 15'h5A3C,
  parameter logic [HIST_W-1:0] PAT_B = 15'h2B17
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic [BUS_W-1:0] data_i,
  input logic [BUS_W-1:0] data_o,
  input logic             match_o
);
  localparam logic [BUS_W-1:0] KEEP = ~(BUS_W'(1) << FLIP_LANE);

  initial begin
    a_pat_nonzero_r1: assert (PAT_A != '0 && PAT_B != '0);
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (data_o == '0 && !match_o));

  p_passthrough_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((data_o & KEEP) == ($past(data_i) & KEEP)));

  p_flip_lane_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (data_o[FLIP_LANE] == ($past(data_i[FLIP_LANE]) ^ match_o)));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(match_o));

  p_newest_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (match_o && !$past(rst) && $past(valid_i)) |->
      ($past(data_i[TAP_A]) == PAT_A[0] && $past(data_i[TAP_B]) == PAT_B[0]));
endmodule

bind lane_trigger_corruptor lane_trigger_corruptor_chk #(
  .BUS_W(BUS_W), .HIST_W(HIST_W), .TAP_A(TAP_A), .TAP_B(TAP_B),
  .FLIP_LANE(FLIP_LANE), .PAT_A(PAT_A), .PAT_B(PAT_B)
) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .data_i(data_i),
  .data_o(data_o), .match_o(match_o)
);

// File: tb/lane_trigger_corruptor_bench.sv
module lane_trigger_corruptor_bench;
  localparam logic [14:0] PA = 15'h5A3C;
  localparam logic [14:0] PB = 15'h2B17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic match_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [14:0] ma, mb;

  always #5 clk = ~clk;

  lane_trigger_corruptor u_lane_trigger_corruptor (
    .clk(clk), .rst(rst), .valid_i(valid_i), .data_i(data_i),
    .data_o(data_o), .match_o(match_o)
  );

  // {valid, data}: patterns far from the trigger, pure pass-through
  localparam logic [8:0] STIM [10] = '{
    9'h1FF, 9'h100, 9'h0FF, 9'h155, 9'h0AA,
    9'h112, 9'h034, 9'h1C3, 9'h17E, 9'h081
  };

  task automatic chk(input string req, input logic [7:0] ad, input logic [7:0] ed,
                     input logic am, input logic em);
    checks++;
    if (ad !== ed || am !== em) begin
      errors++;
      $display("FAIL %s: data_o=%h match_o=%b expected data_o=%h match_o=%b",
               req, ad, am, ed, em);
    end
  endtask

  // one cycle: drive, clock, check against the reference model
  task automatic xfer(input string req, input logic v, input logic [7:0] d);
    logic m;
    @(negedge clk);
    valid_i = v;
    data_i  = d;
    if (v) begin
      ma = {ma[13:0], d[0]};
      mb = {mb[13:0], d[2]};
    end
    m = (ma == PA) && (mb == PB);
    @(posedge clk);
    #1;
    chk(req, data_o, d ^ (m ? 8'h02 : 8'h00), match_o, m);
  endtask

  function automatic logic [7:0] lanes(input logic [7:0] fill, input logic a, input logic b);
    return {fill[7:3], b, fill[1], a};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    valid_i = 1'b0;
    @(posedge clk);
    #1;
    ma = '0;
    mb = '0;
    chk("R1 reset clear", data_o, 8'h00, match_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    ma = '0;
    mb = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state", data_o, 8'h00, match_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < 10; i++)
      xfer("R5 pass-through table", STIM[i][8], STIM[i][7:0]);

    // Full trigger: oldest pattern bit first; no match before the last
    do_reset();
    for (int i = 14; i >= 0; i--)
      xfer(i == 0 ? "R4 corrupt completing transfer" : "R3 no early match",
           1'b1, lanes(8'hA5 ^ 8'(i * 37), PA[i], PB[i]));
    // idle cycles with lanes against the pattern: match held, bit1 still flipped
    xfer("R6 hold idle", 1'b0, 8'hFA);
    xfer("R6 hold idle", 1'b0, 8'h00);
    xfer("R9 flag aligned idle", 1'b0, 8'h02);
    // breaking strobed transfer clears match in the same output cycle
    xfer("R7 break clears", 1'b1, lanes(8'h3C, ~PA[0], PB[0]));
    xfer("R7 stays clear", 1'b0, 8'h02);

    // Interleaved non-strobed noise must not enter history
    do_reset();
    for (int i = 14; i >= 0; i--) begin
      xfer("R2 noise not stored", 1'b0, lanes(8'h5A, ~PA[i], ~PB[i]));
      xfer(i == 0 ? "R2 match with gaps" : "R2 shift on strobe",
           1'b1, lanes(8'hC3, PA[i], PB[i]));
    end

    // One lane only holds its pattern
    do_reset();
    for (int i = 14; i >= 0; i--)
      xfer(i == 0 ? "R8 single lane no match" : "R8 partial",
           1'b1, lanes(8'h66, PA[i], (i == 7) ? ~PB[i] : PB[i]));

    // Reset while matched
    do_reset();
    for (int i = 14; i >= 0; i--)
      xfer("R3 rematch", 1'b1, lanes(8'h0F, PA[i], PB[i]));
    do_reset();
    xfer("R1 history cleared", 1'b1, lanes(8'h0F, PA[0], PB[0]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule